// File: doc/BRIEF.md
# Interval Timer with Pulse Output

This block is a 16-bit down-counter with a 16-bit reload latch, written through a small byte-wide register window. A write to the high byte of the counter starts a run: the counter takes the full latch value, the timer's interrupt flag is cleared and the output pin state goes low. The counter then steps down once per clock-enable tick. When it has run through zero and one more tick has passed, the timer expires.

In one-shot mode only the first expiry after a start counts: it sets the flag and drives the pin state high. The counter keeps stepping down afterwards, but it raises nothing more until the next start. In free-running mode every expiry sets the flag, toggles the pin state and reloads the counter from the latch, so the pin carries a square wave. A control bit chooses whether the pin state reaches the output. The interrupt request follows the flag gated by one enable bit. That enable bit uses set/clear write semantics.

Top module: `pulse_timer`

## Requirements
- R1: After reset the flag and the enable bit are 0, both control bits are 0, `irq` is low, and `pin_out` is high (idle level while the pin is not driven).
- R2: A write to address 0 (counter low) stores `wdata` into the low latch byte only. It starts nothing: no expiry follows from it. A later start uses the stored byte.
- R3: A write to address 1 (counter high) stores `wdata` into the high latch byte and loads the counter with {`wdata`, low latch}. In the same edge it clears the flag, sets the pin state low and arms the one-shot.
- R4: With the counter loaded with N at clock edge E0 and a tick on every edge, the flag is still clear after edge E(N+1) and is set after edge E(N+2).
- R5: With control bit 6 set (free-run), every expiry reloads the counter from the latch, sets the flag and toggles the pin state, giving a period of N+2 ticks.
- R6: With control bit 6 clear (one-shot), only the first expiry after a start sets the flag and drives the pin state high. Later passes of the counter through zero raise nothing.
- R7: A write to address 3 (latch high) or address 2 (latch low) changes only the latch. A run in progress keeps its expiry time, and the new latch value is used at the next reload.
- R8: A write to address 5 (flag register) clears the flag when `wdata` bit 0 is 1. When bit 0 is 0 the write has no effect.
- R9: A write to address 6 (enable register) with `wdata` bit 7 set sets the enable bit if `wdata` bit 0 is 1. With bit 7 clear, it clears the enable bit if `wdata` bit 0 is 1. When bit 0 is 0 the write leaves the enable bit unchanged.
- R10: `irq` is high exactly while both the flag and the enable bit are set.
- R11: Control register (address 4) bit 7 drives the pin state onto `pin_out`. With bit 7 clear, `pin_out` stays high.
- R12: The counter advances only on edges where `ce` is high. Register writes take effect on any edge.
- R13: When an expiry and a flag-clear write fall on the same edge, the flag ends set. When an expiry and a start fall on the same edge, the start wins and the run begins anew.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce | input | 1 | Count tick enable |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| pin_out | output | 1 | Timer pulse/square-wave pin |
| irq | output | 1 | Interrupt request |

## Verification
Two functions can fall on the same clock edge: the expiry that sets the flag, and a register write that clears the flag or restarts the counter. The bench places a flag-clear write exactly on the expiry edge of a short one-shot run, and expects the flag to survive. It also places a restart on the expiry edge, and expects the flag to stay clear and a fresh expiry N+2 ticks later. Expiry edges are computed from the loaded value, and the bench sweeps several small latch values in both modes.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    // register window
    localparam int unsigned A_CTR_LO  = 0;
    localparam int unsigned A_CTR_HI  = 1;
    localparam int unsigned A_LAT_LO  = 2;
    localparam int unsigned A_LAT_HI  = 3;
    localparam int unsigned A_CTRL    = 4;
    localparam int unsigned A_FLAG    = 5;
    localparam int unsigned A_ENABLE  = 6;

    // control bits
    localparam int unsigned CTL_DRIVE = 7;
    localparam int unsigned CTL_FREE  = 6;

    // flag / enable register bits
    localparam int unsigned IE_SETSEL = 7;
    localparam int unsigned TMR_BIT   = 0;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [DATA_W-1:0]     wdata,
    output logic [2*DATA_W-1:0]   latch,
    output logic [2*DATA_W-1:0]   load_value,
    output logic                  load,
    output logic                  flag_clr,
    output logic                  drive,
    output logic                  free_run,
    output logic                  ien
);
    typedef struct packed {
        logic [DATA_W-1:0] lat_lo;
        logic [DATA_W-1:0] lat_hi;
        logic              drive;
        logic              free;
        logic              ien;
    } regs_t;

    regs_t r_d, r_q;
    logic  sel_lo, sel_hi, sel_ctrl, sel_flag, sel_en;

    always_comb begin
        sel_lo   = wr_en && ((addr == ADDR_W'(A_CTR_LO)) || (addr == ADDR_W'(A_LAT_LO)));
        sel_hi   = wr_en && ((addr == ADDR_W'(A_CTR_HI)) || (addr == ADDR_W'(A_LAT_HI)));
        sel_ctrl = wr_en && (addr == ADDR_W'(A_CTRL));
        sel_flag = wr_en && (addr == ADDR_W'(A_FLAG));
        sel_en   = wr_en && (addr == ADDR_W'(A_ENABLE));

        r_d = r_q;
        if (sel_lo) r_d.lat_lo = wdata;
        if (sel_hi) r_d.lat_hi = wdata;
        if (sel_ctrl) begin
            r_d.drive = wdata[CTL_DRIVE];
            r_d.free  = wdata[CTL_FREE];
        end
        if (sel_en && wdata[TMR_BIT]) begin
            r_d.ien = wdata[IE_SETSEL];
        end

        load       = wr_en && (addr == ADDR_W'(A_CTR_HI));
        load_value = {wdata, r_q.lat_lo};
        flag_clr   = sel_flag && wdata[TMR_BIT];
        latch      = {r_q.lat_hi, r_q.lat_lo};
        drive      = r_q.drive;
        free_run   = r_q.free;
        ien        = r_q.ien;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end
endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce,
    input  logic             load,
    input  logic [CNT_W-1:0] load_value,
    input  logic [CNT_W-1:0] latch,
    input  logic             free_run,
    output logic             expire
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             uf;     // counter passed through zero on the last tick
        logic             armed;  // one-shot still waiting for its expiry
    } core_t;

    core_t c_d, c_q;

    always_comb begin
        c_d    = c_q;
        expire = 1'b0;
        if (load) begin
            c_d.cnt   = load_value;
            c_d.uf    = 1'b0;
            c_d.armed = 1'b1;
        end else if (ce) begin
            expire = c_q.uf && (c_q.armed || free_run);
            if (c_q.uf && free_run) c_d.cnt = latch;
            else                    c_d.cnt = c_q.cnt - CNT_W'(1);
            c_d.uf = (c_q.cnt == '0);
            if (c_q.uf) c_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end
endmodule

// File: rtl/tmr_out.sv
module tmr_out (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic expire,
    input  logic free_run,
    input  logic flag_clr,
    input  logic ien,
    input  logic drive,
    output logic flag,
    output logic pin_out,
    output logic irq
);
    typedef struct packed {
        logic flag;
        logic pin;
    } out_t;

    out_t o_d, o_q;

    always_comb begin
        o_d = o_q;
        if (load) begin
            o_d.flag = 1'b0;
            o_d.pin  = 1'b0;
        end else if (expire) begin
            o_d.flag = 1'b1;
            o_d.pin  = free_run ? ~o_q.pin : 1'b1;
        end else if (flag_clr) begin
            o_d.flag = 1'b0;
        end
        flag    = o_q.flag;
        pin_out = drive ? o_q.pin : 1'b1;
        irq     = o_q.flag && ien;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end
endmodule

// File: rtl/pulse_timer.sv
module pulse_timer #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              pin_out,
    output logic              irq
);
    localparam int CNT_W = 2 * DATA_W;

    logic [CNT_W-1:0] latch_w, load_value_w;
    logic load_w, flag_clr_w, drive_w, free_w, ien_w, expire_w, flag_w;

    tmr_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .latch(latch_w), .load_value(load_value_w), .load(load_w),
        .flag_clr(flag_clr_w), .drive(drive_w), .free_run(free_w), .ien(ien_w)
    );

    tmr_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .ce(ce), .load(load_w),
        .load_value(load_value_w), .latch(latch_w), .free_run(free_w),
        .expire(expire_w)
    );

    tmr_out u_out (
        .clk(clk), .rst_n(rst_n), .load(load_w), .expire(expire_w),
        .free_run(free_w), .flag_clr(flag_clr_w), .ien(ien_w), .drive(drive_w),
        .flag(flag_w), .pin_out(pin_out), .irq(irq)
    );
endmodule

// File: rtl/pulse_timer_chk.sv
module pulse_timer_chk #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic              load,
    input logic              expire,
    input logic              flag,
    input logic              ien,
    input logic              drive,
    input logic              pin_out,
    input logic              irq
);
    // a start clears the flag
    assert_load_clears_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !flag);

    // a start with the pin driven pulls the pin low
    assert_load_pin_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (load && drive) |=> !pin_out);

    // the flag can only rise from an expiry
    assert_flag_from_expiry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(expire));

    // a flag-clear write without a competing event leaves the flag clear
    assert_flag_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(5) && wdata[0] && !expire) |=> !flag);

    // enable set-write
    assert_enable_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(6) && wdata[7] && wdata[0]) |=> ien);

    // no tick and no write: nothing observable moves
    assert_idle_stable_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce && !wr_en) |=> ($stable(flag) && $stable(pin_out) && $stable(irq)));

    // expiry beats a simultaneous flag clear
    assert_set_wins_R13: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> flag);
endmodule

bind pulse_timer pulse_timer_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ce(ce), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .load(load_w), .expire(expire_w), .flag(flag_w), .ien(ien_w), .drive(drive_w),
    .pin_out(pin_out), .irq(irq)
);

// File: tb/tb_pulse_timer.sv
module tb_pulse_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ce = 1'b1;
    logic       wr_en = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       pin_out, irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    pulse_timer dut (
        .clk(clk), .rst_n(rst_n), .ce(ce), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .pin_out(pin_out), .irq(irq)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    // called at a negedge; the write lands on the next posedge
    task automatic wr(input int a, input int d);
        wr_en = 1'b1;
        addr  = 4'(a);
        wdata = 8'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic start(input int n);
        wr(0, n & 8'hff);
        wr(1, (n >> 8) & 8'hff);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int lens_os[8] = '{0, 1, 2, 3, 7, 255, 256, 300};
        int lens_fr[5] = '{0, 1, 2, 5, 9};
        bit exp_pin;
        int ticks;

        wait_n(4);
        rst_n = 1'b1;
        wait_n(1);
        // R1 reset state
        chk("R1 irq", irq, 0);
        chk("R1 pin_out", pin_out, 1);

        // R2: low write alone starts nothing, but stores the byte
        wr(4, 8'h80);           // drive on, one-shot
        wr(6, 8'h81);           // enable on
        wr(0, 3);
        wait_n(20);
        chk("R2 no start irq", irq, 0);
        chk("R2 no start pin", pin_out, 0);
        wr(1, 0);               // start with {0,3}
        wait_n(4);
        chk("R2 low byte used, before", irq, 0);
        wait_n(1);
        chk("R2 low byte used, expiry", irq, 1);

        // R3: start clears flag and pin
        wr(1, 0);
        chk("R3 flag cleared", irq, 0);
        chk("R3 pin low", pin_out, 0);
        wait_n(10);

        // R4/R6 one-shot sweep
        foreach (lens_os[i]) begin
            int n = lens_os[i];
            wr(5, 1);
            start(n);
            wait_n(n + 1);
            chk($sformatf("R4 n=%0d before", n), irq, 0);
            chk($sformatf("R6 n=%0d pin before", n), pin_out, 0);
            wait_n(1);
            chk($sformatf("R4 n=%0d expiry", n), irq, 1);
            chk($sformatf("R6 n=%0d pin high", n), pin_out, 1);
            wr(5, 1);
            wait_n(n + 5);
            chk($sformatf("R6 n=%0d no refire", n), irq, 0);
            chk($sformatf("R6 n=%0d pin held", n), pin_out, 1);
        end

        // R6 long: counter wraps again in one-shot without raising anything
        start(0);
        wait_n(2);
        chk("R6 wrap first", irq, 1);
        wr(5, 1);
        wait_n(65600);
        chk("R6 wrap no flag", irq, 0);
        chk("R6 wrap pin", pin_out, 1);

        // R5 free-run sweep
        wr(4, 8'hC0);
        foreach (lens_fr[i]) begin
            int n = lens_fr[i];
            start(n);
            wr(5, 1);       // clear any flag; costs one tick of the period
            exp_pin = 1'b0;
            wait_n(n);
            chk($sformatf("R5 n=%0d p1 before", n), pin_out, exp_pin);
            chk($sformatf("R5 n=%0d flag before", n), irq, 0);
            wait_n(1);
            exp_pin = ~exp_pin;
            chk($sformatf("R5 n=%0d p1 toggle", n), pin_out, exp_pin);
            chk($sformatf("R5 n=%0d flag set", n), irq, 1);
            for (int p = 2; p <= 4; p++) begin
                wait_n(n + 1);
                chk($sformatf("R5 n=%0d p%0d before", n, p), pin_out, exp_pin);
                wait_n(1);
                exp_pin = ~exp_pin;
                chk($sformatf("R5 n=%0d p%0d toggle", n, p), pin_out, exp_pin);
            end
        end

        // R7: latch-high write mid-run
        start(10);              // E0
        wait_n(3);              // E3
        wr(3, 1);               // E4, latch becomes 0x010A
        wait_n(7);              // E11
        chk("R7 keeps time before", pin_out, 0);
        wait_n(1);              // E12
        chk("R7 keeps time expiry", pin_out, 1);
        wait_n(267);
        chk("R7 new latch before", pin_out, 1);
        wait_n(1);
        chk("R7 new latch reload", pin_out, 0);

        // R8, R9, R10 on a set flag
        wr(4, 8'h80);
        start(2);
        wait_n(4);
        chk("R10 flag and enable", irq, 1);
        wr(5, 8'hFE);
        chk("R8 bit0 clear ignored", irq, 1);
        wr(6, 8'h01);
        chk("R9 clear enable", irq, 0);
        wr(6, 8'h80);
        chk("R9 set without bit0", irq, 0);
        wr(6, 8'h81);
        chk("R9 set enable", irq, 1);
        wr(6, 8'h00);
        chk("R9 clear without bit0", irq, 1);
        wr(5, 8'h01);
        chk("R8 clear flag", irq, 0);

        // R11: pin not driven stays high
        wr(4, 8'h00);
        start(4);
        chk("R11 undriven high after start", pin_out, 1);
        wait_n(8);
        chk("R11 undriven high after expiry", pin_out, 1);
        wr(4, 8'h80);
        chk("R11 driven shows state", pin_out, 1);

        // R12: ticks only when ce is high
        wr(5, 1);
        ce = 1'b0;
        start(4);
        ticks = 0;
        for (int i = 0; i < 40; i++) begin
            ce = i[0];
            @(negedge clk);
            if (ce) begin
                ticks++;
                if (ticks == 5) chk("R12 gated before", irq, 0);
                if (ticks == 6) begin
                    chk("R12 gated expiry", irq, 1);
                    break;
                end
            end else if (ticks == 5) begin
                chk("R12 hold no tick", irq, 0);
            end
        end
        ce = 1'b1;

        // R13: flag clear on expiry edge
        wr(5, 1);
        start(3);               // E0
        wait_n(4);              // E4
        wr(5, 1);               // E5 = expiry edge
        chk("R13 set wins", irq, 1);

        // R13: restart on expiry edge
        wr(5, 1);
        start(3);               // E0
        wait_n(4);
        wr(1, 0);               // E5 restart with {0,3}
        chk("R13 restart wins", irq, 0);
        wait_n(4);
        chk("R13 restart before", irq, 0);
        wait_n(1);
        chk("R13 restart expiry", irq, 1);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule